// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This block keeps wall time as a single binary count split into whole seconds and a sub-second fraction. A one-cycle `tick` strobe, already brought into this clock domain from a 32.768 kHz low-power oscillator, advances the fraction. When the fraction passes its top value it returns to zero and carries into the seconds field. With the default widths, 15 fraction bits and 32 seconds bits, the fraction carries once every 32768 ticks. Counting needs the enable bit in the control register. It stops while the unit is reported non-valid or failed, and it stays frozen once the whole count has wrapped, until software acknowledges the overflow.

The seconds field is compared against a programmable alarm-seconds value. When the two become equal, a sticky alarm flag is raised. That flag drives an interrupt only when the alarm interrupt enable is set. Two sticky lock bits in the control register protect the time value: once either lock is set, the time registers can no longer be rewritten until the next reset.

Software reaches the block through a plain write strobe and a combinational read port. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Register word addresses:

| Address | Register |
|---|---|
| 0 | seconds |
| 1 | fraction |
| 2 | alarm seconds |
| 3 | alarm fraction, always zero |
| 4 | control |
| 5 | status |
| 6 | interrupt enable |

Top module: `sec_rtc_core`

## Requirements
- R1: After reset, seconds and fraction read 0, alarm seconds reads all ones (the unset value), and control, status flags, interrupt enable and `alarm_irq` are all 0.
- R2: Each `tick` cycle in which counting is allowed advances the count {seconds, fraction} by one. A full fraction rolls to zero and adds one to the seconds.
- R3: No tick advances the count while control bit 3 (enable) is 0, while `nonvalid` is 1, while `failure` is 1, or while the overflow flag is set. Status bit 1 mirrors `nonvalid` and status bit 0 mirrors `failure`.
- R4: A tick that wraps the full count from all ones sets the overflow flag (status bit 2, `ovf_flag`) and leaves the count at zero.
- R5: Writing status with bit 2 at 1 clears the overflow flag, and counting resumes. Writing a 0 in bit 2 leaves the flag unchanged. If a wrap and a clear fall in the same cycle, the flag stays set.
- R6: A write to address 0 loads the seconds and zeroes the fraction. A write to address 1 loads only the fraction. A tick in the same cycle as a time write is dropped.
- R7: Control bit 17 (soft lock) or bit 18 (hard lock) makes writes to addresses 0 and 1 ignored. A lock bit, once written as 1, cannot be cleared by a control write; only reset clears it. Alarm writes are still accepted while locked.
- R8: The cycle after the seconds field becomes equal to alarm seconds, the alarm flag (status bit 4, `alarm_flag`) is set. Address 3 reads zero and ignores writes.
- R9: Writing status with bit 4 at 1 clears the alarm flag, and the flag is not raised again while the seconds field stays equal to alarm seconds. If a new match arrives in the same cycle as the clear, the flag stays set.
- R10: `alarm_irq` is high exactly when the alarm flag is set and interrupt-enable bit 4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per low-power clock period |
| nonvalid | input | 1 | Unit reported non-valid; halts counting |
| failure | input | 1 | Unit reported failed; halts counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register word address for reads |
| rd_data | output | 32 | Read data, combinational |
| alarm_flag | output | 1 | Sticky alarm match flag |
| ovf_flag | output | 1 | Sticky full-count wrap flag |
| alarm_irq | output | 1 | Alarm interrupt, gated by the enable |

## Verification
Two pairs of events can collide in one clock edge. In the first, the seconds field reaches alarm seconds in the cycle that software writes a 1 to clear the alarm flag. In the second, a tick wraps the full count in the cycle that software clears the overflow flag. The bench stages each collision: it loads the count one tick short of the event, then drives the tick and the status clear into the same edge. It passes only if the sticky flag reads 1 afterwards, because setting takes priority over clearing. A dropped tick during a time write is staged the same way and is judged by the fraction value that the write leaves behind.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    SEL_TSEC  = 3'd0,
    SEL_TFRAC = 3'd1,
    SEL_ASEC  = 3'd2,
    SEL_AFRAC = 3'd3,
    SEL_CTL   = 3'd4,
    SEL_STAT  = 3'd5,
    SEL_IEN   = 3'd6
  } reg_sel_e;

  localparam int CTL_RUN_BIT   = 3;
  localparam int CTL_SOFT_BIT  = 17;
  localparam int CTL_HARD_BIT  = 18;
  localparam int ST_FAIL_BIT   = 0;
  localparam int ST_NVAL_BIT   = 1;
  localparam int ST_OVF_BIT    = 2;
  localparam int ST_ALARM_BIT  = 4;
  localparam int IEN_ALARM_BIT = 4;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  logic wr_ien,
  input  logic run_d,
  input  logic soft_d,
  input  logic hard_d,
  input  logic ien_d,
  output logic run_en,
  output logic soft_lock,
  output logic hard_lock,
  output logic ien_alarm
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en    <= 1'b0;
      soft_lock <= 1'b0;
      hard_lock <= 1'b0;
      ien_alarm <= 1'b0;
    end else begin
      if (wr_ctl) begin
        run_en    <= run_d;
        soft_lock <= soft_lock | soft_d;
        hard_lock <= hard_lock | hard_d;
      end
      if (wr_ien) ien_alarm <= ien_d;
    end
  end

  // R7: lock bits survive any control write once set
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_lock || hard_lock) |=> (soft_lock || hard_lock));
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  logic              wr_sec,
  input  logic              wr_frac,
  input  logic [SEC_W-1:0]  sec_d,
  input  logic [FRAC_W-1:0] frac_d,
  input  logic              clr_ovf,
  output logic [SEC_W-1:0]  sec,
  output logic [FRAC_W-1:0] frac,
  output logic              ovf
);
  localparam int CW = SEC_W + FRAC_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          carry;
  logic          run;

  assign {carry, cnt_nxt} = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign run  = tick && go && !ovf && !wr_sec && !wr_frac;
  assign sec  = cnt_q[CW-1:FRAC_W];
  assign frac = cnt_q[FRAC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      if (wr_sec)       cnt_q <= {sec_d, {FRAC_W{1'b0}}};
      else if (wr_frac) cnt_q[FRAC_W-1:0] <= frac_d;
      else if (run)     cnt_q <= cnt_nxt;
      if (run && carry)  ovf <= 1'b1;
      else if (clr_ovf)  ovf <= 1'b0;
    end
  end

  // R2: an allowed tick moves the count up by exactly one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !carry) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
  // R3: with no allowed tick and no write the count holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && go && !ovf) && !wr_sec && !wr_frac) |=> $stable(cnt_q));
  // R4: wrap lands on zero with the flag raised
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && carry) |=> (ovf && cnt_q == '0));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] sec,
  input  logic             wr_asec,
  input  logic [SEC_W-1:0] asec_d,
  input  logic             clr_flag,
  input  logic             ien,
  output logic [SEC_W-1:0] asec,
  output logic             flag,
  output logic             irq
);
  logic match;
  logic match_q;
  logic rise;

  assign match = (sec == asec);
  assign rise  = match && !match_q;
  assign irq   = flag && ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asec    <= '1;
      match_q <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (wr_asec) asec <= asec_d;
      match_q <= match;
      if (rise)          flag <= 1'b1;
      else if (clr_flag) flag <= 1'b0;
    end
  end

  // R8: a fresh equality raises the flag on the following edge
  assert_alarm_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> flag);
  // R9: a clear with no new equality drops the flag
  assert_alarm_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !rise) |=> !flag);
endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        nonvalid,
  input  logic        failure,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        alarm_flag,
  output logic        ovf_flag,
  output logic        alarm_irq
);
  import rtc_pkg::*;

  logic              run_en, soft_lock, hard_lock, ien_alarm;
  logic              locked, go;
  logic              wr_sec, wr_frac, wr_asec, wr_ctl, wr_ien, wr_stat;
  logic [SEC_W-1:0]  sec, asec;
  logic [FRAC_W-1:0] frac;

  assign locked  = soft_lock || hard_lock;
  assign go      = run_en && !nonvalid && !failure;
  assign wr_sec  = wr_en && (wr_addr == SEL_TSEC)  && !locked;
  assign wr_frac = wr_en && (wr_addr == SEL_TFRAC) && !locked;
  assign wr_asec = wr_en && (wr_addr == SEL_ASEC);
  assign wr_ctl  = wr_en && (wr_addr == SEL_CTL);
  assign wr_ien  = wr_en && (wr_addr == SEL_IEN);
  assign wr_stat = wr_en && (wr_addr == SEL_STAT);

  rtc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctl   (wr_ctl),
    .wr_ien   (wr_ien),
    .run_d    (wr_data[CTL_RUN_BIT]),
    .soft_d   (wr_data[CTL_SOFT_BIT]),
    .hard_d   (wr_data[CTL_HARD_BIT]),
    .ien_d    (wr_data[IEN_ALARM_BIT]),
    .run_en   (run_en),
    .soft_lock(soft_lock),
    .hard_lock(hard_lock),
    .ien_alarm(ien_alarm)
  );

  rtc_time_cnt #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .go     (go),
    .wr_sec (wr_sec),
    .wr_frac(wr_frac),
    .sec_d  (wr_data[SEC_W-1:0]),
    .frac_d (wr_data[FRAC_W-1:0]),
    .clr_ovf(wr_stat && wr_data[ST_OVF_BIT]),
    .sec    (sec),
    .frac   (frac),
    .ovf    (ovf_flag)
  );

  rtc_alarm #(.SEC_W(SEC_W)) u_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .sec     (sec),
    .wr_asec (wr_asec),
    .asec_d  (wr_data[SEC_W-1:0]),
    .clr_flag(wr_stat && wr_data[ST_ALARM_BIT]),
    .ien     (ien_alarm),
    .asec    (asec),
    .flag    (alarm_flag),
    .irq     (alarm_irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      SEL_TSEC:  rd_data = 32'(sec);
      SEL_TFRAC: rd_data = 32'(frac);
      SEL_ASEC:  rd_data = 32'(asec);
      SEL_CTL: begin
        rd_data[CTL_RUN_BIT]  = run_en;
        rd_data[CTL_SOFT_BIT] = soft_lock;
        rd_data[CTL_HARD_BIT] = hard_lock;
      end
      SEL_STAT: begin
        rd_data[ST_FAIL_BIT]  = failure;
        rd_data[ST_NVAL_BIT]  = nonvalid;
        rd_data[ST_OVF_BIT]   = ovf_flag;
        rd_data[ST_ALARM_BIT] = alarm_flag;
      end
      SEL_IEN:   rd_data[IEN_ALARM_BIT] = ien_alarm;
      default:   rd_data = '0;
    endcase
  end

  // R7: a locked unit keeps its time across an attempted seconds write
  assert_locked_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && wr_addr == SEL_TSEC && !(tick && go && !ovf_flag)) |=> $stable(sec));
endmodule

// File: tb/sec_rtc_core_test.sv
module sec_rtc_core_test;
  localparam int SW = 4;
  localparam int FW = 3;
  localparam int FULL = 1 << (SW + FW);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, nonvalid = 1'b0, failure = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        alarm_flag, ovf_flag, alarm_irq;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  sec_rtc_core #(.SEC_W(SW), .FRAC_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .nonvalid(nonvalid), .failure(failure),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .alarm_flag(alarm_flag), .ovf_flag(ovf_flag), .alarm_irq(alarm_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk_reg("R1 sec", 3'd0, 0);
    chk_reg("R1 frac", 3'd1, 0);
    chk_reg("R1 alarm sec", 3'd2, (1 << SW) - 1);
    chk_reg("R1 ctl", 3'd4, 0);
    chk_reg("R1 status", 3'd5, 0);
    chk_reg("R1 ien", 3'd6, 0);
    chk("R1 irq", {31'd0, alarm_irq}, 0);

    // R3: disabled counter ignores ticks
    step();
    chk_reg("R3 disabled", 3'd1, 0);

    // R2/R4/R8: full sweep through wrap
    wr(3'd4, 32'h8);
    for (int k = 1; k <= FULL; k++) begin
      int m;
      m = k % FULL;
      step();
      chk_reg("R2 sec", 3'd0, m >> FW);
      chk_reg("R2 frac", 3'd1, m % (1 << FW));
      chk("R4 ovf", {31'd0, ovf_flag}, (k == FULL) ? 1 : 0);
      chk("R8 flag", {31'd0, alarm_flag}, (k >= FULL - (1 << FW)) ? 1 : 0);
      chk("R10 irq off", {31'd0, alarm_irq}, 0);
    end
    step();
    chk_reg("R3 frozen by ovf", 3'd1, 0);
    wr(3'd5, 32'h0);
    chk("R5 zero write", {31'd0, ovf_flag}, 1);
    wr(3'd5, 32'h4);
    chk("R5 clear", {31'd0, ovf_flag}, 0);
    chk("R9 untouched", {31'd0, alarm_flag}, 1);
    wr(3'd6, 32'h10);
    chk("R10 irq on", {31'd0, alarm_irq}, 1);
    wr(3'd6, 32'h0);
    chk("R10 irq masked", {31'd0, alarm_irq}, 0);
    wr(3'd5, 32'h10);
    chk("R9 clear", {31'd0, alarm_flag}, 0);
    step();
    chk_reg("R5 resumes", 3'd1, 1);

    // R3 stop conditions
    wr(3'd4, 32'h0);
    step();
    chk_reg("R3 enable off", 3'd1, 1);
    wr(3'd4, 32'h8);
    nonvalid = 1'b1;
    step();
    chk_reg("R3 nonvalid", 3'd1, 1);
    chk_reg("R3 status nv", 3'd5, 32'h2);
    nonvalid = 1'b0; failure = 1'b1;
    step();
    chk_reg("R3 failure", 3'd1, 1);
    chk_reg("R3 status fail", 3'd5, 32'h1);
    failure = 1'b0;
    step();
    chk_reg("R2 after stops", 3'd1, 2);

    // R6 writes
    wr(3'd0, 32'h5);
    chk_reg("R6 sec", 3'd0, 5);
    chk_reg("R6 frac zero", 3'd1, 0);
    wr(3'd1, 32'h6);
    chk_reg("R6 frac", 3'd1, 6);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h1;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk_reg("R6 tick dropped", 3'd1, 1);

    // R8 alarm match
    wr(3'd2, 32'h9);
    wr(3'd0, 32'h8);
    wr(3'd1, 32'h7);
    chk("R8 before", {31'd0, alarm_flag}, 0);
    step();
    chk_reg("R8 sec", 3'd0, 9);
    chk("R8 after", {31'd0, alarm_flag}, 1);
    wr(3'd5, 32'h10);
    @(negedge clk);
    chk("R9 no re-raise", {31'd0, alarm_flag}, 0);
    wr(3'd3, 32'h5);
    chk_reg("R8 alarm frac", 3'd3, 0);

    // R9 contention: match and clear on the same edge
    wr(3'd0, 32'h8);
    wr(3'd1, 32'h7);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'h10;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 set wins", {31'd0, alarm_flag}, 1);

    // R5 contention: wrap and clear on the same edge
    wr(3'd0, 32'hF);
    wr(3'd1, 32'h7);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'h4;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R5 wrap wins", {31'd0, ovf_flag}, 1);
    chk_reg("R4 zero", 3'd0, 0);

    // R7 soft lock
    wr(3'd4, 32'h20008);
    wr(3'd0, 32'h3);
    chk_reg("R7 soft sec", 3'd0, 0);
    wr(3'd1, 32'h4);
    chk_reg("R7 soft frac", 3'd1, 0);
    wr(3'd4, 32'h0);
    chk_reg("R7 soft sticky", 3'd4, 32'h20000);
    wr(3'd2, 32'h2);
    chk_reg("R7 alarm open", 3'd2, 2);

    // R7 hard lock
    do_reset();
    chk_reg("R7 reset unlock", 3'd4, 0);
    wr(3'd4, 32'h40000);
    wr(3'd0, 32'h3);
    chk_reg("R7 hard sec", 3'd0, 0);
    wr(3'd4, 32'h0);
    chk_reg("R7 hard sticky", 3'd4, 32'h40000);
    do_reset();
    wr(3'd0, 32'h3);
    chk_reg("R6 unlocked write", 3'd0, 3);

    finish_run();
  end
endmodule